// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is a serial chain of boundary cells. It sits between the core logic and the device pins. A test access port controller drives it with one-cycle data-register strobes (capture, shift, update), a serial data input and a 3-bit instruction code. The block returns the serial data output.

Every cell has two flops:
- a capture/shift flop, which either loads a parallel value or takes the bit from its upstream neighbour;
- an update (hold) flop, present on the cells that feed pins, which keeps test data between updates.

Input pins have one cell each. Each output pin has two cells: a data cell and a control cell that gates the pin's output enable.

The instruction sets three things: whether the chain or a one-bit bypass flop sits between serial in and serial out, whether the pins carry core data or held test data, and whether all drivers are switched off. In normal operation the pin paths are combinational pass-throughs. The block adds no delay to functional signals.

Top module: `bsr_chain`

## Requirements
- R1: While `rst` is high at a clock edge, all capture, hold and bypass flops clear to 0. Under EXTEST after reset this gives `pin_tx_o` = 0, `pin_oe_o` = 0 and `tdo_o` = 0.
- R2: Chain position 0 is next to `tdi_i`. Positions 0..N_IN-1 are input cells. Output pin j uses data cell N_IN+2j and control cell N_IN+2j+1. On each clock with `shift_i` high, and the chain selected, every bit moves one position toward the last cell. `tdo_o` shows the last cell.
- R3: On a capture, and with the chain selected, the cells load as follows. Input cells load `pin_in_i`. Control cells load `core_oe_i`. Data cells load `pin_back_i` under EXTEST and `core_tx_i` under SAMPLE.
- R4: Hold flops load from the capture flops only on a clock with `upd_i` high and the chain selected. Otherwise they keep their value.
- R5: Under SAMPLE and BYPASS the block leaves the pins alone: `pin_tx_o` = `core_tx_i` and `pin_oe_o` = `core_oe_i`. `core_rx_o` always equals `pin_in_i`.
- R6: Under EXTEST, `pin_tx_o[j]` is the held data cell of pin j and `pin_oe_o[j]` is its held control cell. A control value of 0 turns the driver off.
- R7: Under BYPASS a single flop links `tdi_i` to `tdo_o` with one clock of delay. A capture loads it with 0.
- R8: Under CLAMP the pins carry the held data and control values, and the bypass flop is the serial path. Capture, shift and update leave the chain and hold flops unchanged.
- R9: Under HIGHZ every `pin_oe_o` bit is 0, and the bypass flop is the serial path. The chain and hold flops are unchanged.
- R10: Instruction codes are EXTEST=0, SAMPLE=1, CLAMP=2, HIGHZ=3 and BYPASS=7. Codes 4, 5 and 6 behave exactly as BYPASS.
- R11: When capture and shift are high in the same clock, capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_i | input | 3 | Current instruction code |
| cap_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| upd_i | input | 1 | Update strobe |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| pin_in_i | input | N_IN | Values on input pins |
| core_rx_o | output | N_IN | Input pin values passed to core |
| core_tx_i | input | N_OUT | Core output data |
| core_oe_i | input | N_OUT | Core output enables |
| pin_back_i | input | N_OUT | Values read back from output pins |
| pin_tx_o | output | N_OUT | Data to output pin drivers |
| pin_oe_o | output | N_OUT | Output pin driver enables |

## Verification
The bench targets the corners where a wrong design would behave differently:
- Serial order: a chain that shifts the wrong way, or taps the wrong cell, returns scrambled bit order at `tdo_o`.
- Data-cell capture source: swapping the EXTEST and SAMPLE sources makes core data appear where pin readback was expected.
- Bypass-class instructions: the bench shifts and strobes heavily under CLAMP, HIGHZ and the unused codes, then reads the chain out under EXTEST. Any leak of strobes into the chain shows as changed bits, and any glitch on the held pin values shows on `pin_tx_o` and `pin_oe_o`.
- Strobe handling: simultaneous capture and shift, and shifting without an update, expose a wrong priority or holds that are not gated.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [2:0] {
    INS_EXTEST = 3'd0,
    INS_SAMPLE = 3'd1,
    INS_CLAMP  = 3'd2,
    INS_HIGHZ  = 3'd3,
    INS_BYPASS = 3'd7
  } ins_e;

  typedef struct packed {
    logic chain_sel;   // boundary chain is the serial path
    logic drive_test;  // pins take held test values
    logic force_off;   // every driver disabled
    logic cap_back;    // data cells capture pin readback
  } mode_t;
endpackage

// File: rtl/bsr_decode.sv
module bsr_decode
  import bsr_pkg::*;
(
  input  logic [2:0] ins,
  output mode_t      mode
);
  always_comb begin
    mode = '0;
    case (ins)
      INS_EXTEST: begin
        mode.chain_sel  = 1'b1;
        mode.drive_test = 1'b1;
        mode.cap_back   = 1'b1;
      end
      INS_SAMPLE: mode.chain_sel = 1'b1;
      INS_CLAMP:  mode.drive_test = 1'b1;
      INS_HIGHZ: begin
        mode.drive_test = 1'b1;
        mode.force_off  = 1'b1;
      end
      default: mode = '0;  // bypass class
    endcase
  end
endmodule

// File: rtl/bsr_cell.sv
module bsr_cell (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic cap,
  input  logic shift,
  input  logic pi,
  input  logic si,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= 1'b0;
    else if (sel) begin
      if (cap)
        q <= pi;
      else if (shift)
        q <= si;
    end
  end

  AST_CAP_LOAD:   assert property (@(posedge clk) disable iff (rst)
                    (sel && cap) |=> q == $past(pi)); // R3
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
                    (sel && shift && !cap) |=> q == $past(si)); // R2
  AST_CELL_IDLE:  assert property (@(posedge clk) disable iff (rst)
                    (!sel) |=> $stable(q)); // R8
endmodule

// File: rtl/bsr_hold.sv
module bsr_hold (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic d,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= 1'b0;
    else if (load)
      q <= d;
  end

  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
                   (!load) |=> $stable(q)); // R4
  AST_HOLD_LOAD: assert property (@(posedge clk) disable iff (rst)
                   load |=> q == $past(d)); // R4
endmodule

// File: rtl/bsr_bypass.sv
module bsr_bypass (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic cap,
  input  logic shift,
  input  logic tdi,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)
      q <= 1'b0;
    else if (sel) begin
      if (cap)
        q <= 1'b0;
      else if (shift)
        q <= tdi;
    end
  end

  AST_BYP_ZERO: assert property (@(posedge clk) disable iff (rst)
                  (sel && cap) |=> q == 1'b0); // R7
  AST_BYP_STEP: assert property (@(posedge clk) disable iff (rst)
                  (sel && shift && !cap) |=> q == $past(tdi)); // R7
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import bsr_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       ins_i,
  input  logic             cap_i,
  input  logic             shift_i,
  input  logic             upd_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  input  logic [N_IN-1:0]  pin_in_i,
  output logic [N_IN-1:0]  core_rx_o,
  input  logic [N_OUT-1:0] core_tx_i,
  input  logic [N_OUT-1:0] core_oe_i,
  input  logic [N_OUT-1:0] pin_back_i,
  output logic [N_OUT-1:0] pin_tx_o,
  output logic [N_OUT-1:0] pin_oe_o
);
  localparam int LEN = N_IN + 2 * N_OUT;

  mode_t          mode;
  logic [LEN-1:0] pi_vec;
  logic [LEN-1:0] si_vec;
  logic [LEN-1:0] cap_q;
  logic           byp_q;
  logic           hold_ld;

  bsr_decode u_dec (.ins(ins_i), .mode(mode));

  assign si_vec  = {cap_q[LEN-2:0], tdi_i};
  assign hold_ld = mode.chain_sel & upd_i;

  for (genvar k = 0; k < N_IN; k++) begin : g_in
    assign pi_vec[k]    = pin_in_i[k];
    assign core_rx_o[k] = pin_in_i[k];
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    localparam int DI = N_IN + 2 * j;
    localparam int CI = DI + 1;
    logic hd, hc;

    assign pi_vec[DI] = mode.cap_back ? pin_back_i[j] : core_tx_i[j];
    assign pi_vec[CI] = core_oe_i[j];

    bsr_hold u_hd (.clk(clk), .rst(rst), .load(hold_ld), .d(cap_q[DI]), .q(hd));
    bsr_hold u_hc (.clk(clk), .rst(rst), .load(hold_ld), .d(cap_q[CI]), .q(hc));

    assign pin_tx_o[j] = mode.drive_test ? hd : core_tx_i[j];
    assign pin_oe_o[j] = mode.force_off ? 1'b0 :
                         (mode.drive_test ? hc : core_oe_i[j]);
  end

  for (genvar k = 0; k < LEN; k++) begin : g_cell
    bsr_cell u_cell (
      .clk(clk), .rst(rst), .sel(mode.chain_sel),
      .cap(cap_i), .shift(shift_i),
      .pi(pi_vec[k]), .si(si_vec[k]), .q(cap_q[k])
    );
  end

  bsr_bypass u_byp (
    .clk(clk), .rst(rst), .sel(!mode.chain_sel),
    .cap(cap_i), .shift(shift_i), .tdi(tdi_i), .q(byp_q)
  );

  assign tdo_o = mode.chain_sel ? cap_q[LEN-1] : byp_q;

  AST_HIGHZ_OFF: assert property (@(posedge clk) disable iff (rst)
                   (ins_i == 3'(INS_HIGHZ)) |-> pin_oe_o == '0); // R9
  AST_SAMPLE_QUIET: assert property (@(posedge clk) disable iff (rst)
                   (ins_i == 3'(INS_SAMPLE)) |->
                   (pin_tx_o == core_tx_i && pin_oe_o == core_oe_i)); // R5
  AST_UNUSED_BYP: assert property (@(posedge clk) disable iff (rst)
                   (ins_i inside {3'd4, 3'd5, 3'd6} && cap_i) |=>
                   (ins_i != 3'(INS_BYPASS) && !(ins_i inside {3'd4, 3'd5, 3'd6})) || tdo_o == 1'b0); // R10
endmodule

// File: tb/bsr_chain_tb_top.sv
module bsr_chain_tb_top;
  localparam int NI = 4;
  localparam int NO = 3;
  localparam int L  = NI + 2 * NO;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic [2:0]    ins = 3'd0;
  logic          cap = 1'b0, shf = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic [NI-1:0] pin_in = '0;
  logic [NO-1:0] core_tx = '0, core_oe = '0, pin_back = '0;
  logic          tdo;
  logic [NI-1:0] core_rx;
  logic [NO-1:0] pin_tx, pin_oe;

  bsr_chain #(.N_IN(NI), .N_OUT(NO)) dut_i (
    .clk(clk), .rst(rst), .ins_i(ins), .cap_i(cap), .shift_i(shf),
    .upd_i(upd), .tdi_i(tdi), .tdo_o(tdo), .pin_in_i(pin_in),
    .core_rx_o(core_rx), .core_tx_i(core_tx), .core_oe_i(core_oe),
    .pin_back_i(pin_back), .pin_tx_o(pin_tx), .pin_oe_o(pin_oe)
  );

  int    vectors = 0;
  int    errors  = 0;
  string tag     = "R1";

  bit ref_chain[$];
  bit ref_hold[L];
  bit ref_byp;

  function automatic bit on_chain(logic [2:0] c);
    return (c == 3'd0) || (c == 3'd1);
  endfunction

  function automatic bit cap_src(int k);
    int j;
    if (k < NI) return pin_in[k];
    j = (k - NI) / 2;
    if (((k - NI) % 2) == 1) return core_oe[j];
    return (ins == 3'd0) ? pin_back[j] : core_tx[j];
  endfunction

  // behavioural reference, advanced at every rising edge
  always @(posedge clk) begin : model
    bit old[$];
    if (rst) begin
      ref_chain = {};
      for (int k = 0; k < L; k++) ref_chain.push_back(1'b0);
      for (int k = 0; k < L; k++) ref_hold[k] = 1'b0;
      ref_byp = 1'b0;
    end else if (on_chain(ins)) begin
      old = ref_chain;
      if (cap) begin
        for (int k = 0; k < L; k++) ref_chain[k] = cap_src(k);
      end else if (shf) begin
        ref_chain.push_front(tdi);
        void'(ref_chain.pop_back());
      end
      if (upd) for (int k = 0; k < L; k++) ref_hold[k] = old[k];
    end else begin
      if (cap) ref_byp = 1'b0;
      else if (shf) ref_byp = tdi;
    end
  end

  task automatic check1(string what, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic          e_tdo;
    logic [NO-1:0] e_tx, e_oe;
    bit            test_drv;
    test_drv = (ins == 3'd0) || (ins == 3'd2) || (ins == 3'd3);
    e_tdo = on_chain(ins) ? ref_chain[L-1] : ref_byp;
    for (int j = 0; j < NO; j++) begin
      e_tx[j] = test_drv ? ref_hold[NI + 2*j] : core_tx[j];
      e_oe[j] = (ins == 3'd3) ? 1'b0 : (test_drv ? ref_hold[NI + 2*j + 1] : core_oe[j]);
    end
    check1("tdo",     8'(tdo),     8'(e_tdo));
    check1("pin_tx",  8'(pin_tx),  8'(e_tx));
    check1("pin_oe",  8'(pin_oe),  8'(e_oe));
    check1("core_rx", 8'(core_rx), 8'(pin_in));
  endtask

  task automatic cyc(logic [2:0] c, logic cp, logic sh, logic up, logic d);
    ins = c; cap = cp; shf = sh; upd = up; tdi = d;
    @(negedge clk);
    compare();
  endtask

  task automatic shift_vec(logic [2:0] c, logic [L-1:0] v);
    for (int i = 0; i < L; i++) cyc(c, 1'b0, 1'b1, 1'b0, v[i]);
  endtask

  task automatic rand_io();
    pin_in = NI'($urandom); core_tx = NO'($urandom);
    core_oe = NO'($urandom); pin_back = NO'($urandom);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : stim
    // R1: reset state under EXTEST
    tag = "R1";
    repeat (3) cyc(3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    cyc(3'd0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R6: load and apply a test vector with mixed enables
    tag = "R6";
    shift_vec(3'd0, 10'b1011001101);
    cyc(3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    repeat (3) cyc(3'd0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R2: ordering seen at tdo
    tag = "R2";
    shift_vec(3'd0, 10'b0110010111);
    shift_vec(3'd0, 10'b0000000000);

    // R3: EXTEST captures readback, SAMPLE captures core data
    tag = "R3";
    pin_in = 4'b1010; core_tx = 3'b011; core_oe = 3'b110; pin_back = 3'b100;
    cyc(3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    shift_vec(3'd0, 10'b1111111111);
    cyc(3'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    shift_vec(3'd1, 10'b0101010101);

    // R4: shifting without update leaves the pins; update then moves them
    tag = "R4";
    cyc(3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    shift_vec(3'd0, 10'b1100110011);
    repeat (2) cyc(3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    cyc(3'd0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R5: SAMPLE and BYPASS keep pins functional
    tag = "R5";
    for (int i = 0; i < 12; i++) begin
      rand_io();
      cyc((i % 2) ? 3'd7 : 3'd1, 1'(i % 3 == 0), 1'b1, 1'(i % 4 == 0), 1'($urandom));
    end

    // R7: bypass flop captures 0 then delays by one
    tag = "R7";
    cyc(3'd7, 1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 12; i++) cyc(3'd7, 1'b0, 1'b1, 1'b0, 1'((i * 5 + 1) % 3 == 0));

    // R8: CLAMP holds pins, chain untouched; read chain back under EXTEST
    tag = "R8";
    shift_vec(3'd0, 10'b1001011010);
    cyc(3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 16; i++) begin
      rand_io();
      cyc(3'd2, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    shift_vec(3'd0, 10'b0000000000);

    // R9: HIGHZ turns every driver off, chain untouched
    tag = "R9";
    shift_vec(3'd0, 10'b1111111111);
    cyc(3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 16; i++) begin
      rand_io();
      cyc(3'd3, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    shift_vec(3'd0, 10'b0000000000);

    // R10: unused codes act as bypass
    tag = "R10";
    for (int c = 4; c < 7; c++) begin
      cyc(3'(c), 1'b1, 1'b0, 1'b1, 1'b1);
      for (int i = 0; i < 6; i++) cyc(3'(c), 1'b0, 1'b1, 1'b1, 1'(i % 2));
    end
    shift_vec(3'd0, 10'b0000000000);

    // R11: capture wins over a simultaneous shift
    tag = "R11";
    pin_in = 4'b0110; core_oe = 3'b101; pin_back = 3'b011;
    cyc(3'd0, 1'b1, 1'b1, 1'b0, 1'b1);
    shift_vec(3'd0, 10'b0000000000);

    // random mix across all codes
    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      rand_io();
      cyc(3'($urandom), 1'($urandom_range(0, 7) == 0), 1'($urandom),
          1'($urandom_range(0, 5) == 0), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule